// File: doc/BRIEF.md
# Prioritized Posted/Pending Interrupt Controller

This block gathers a set of interrupt request lines for a small CPU. A rising edge on any request line records a posted event for that source. A per-source enable mask decides which posted events move into the pending set. A masked event is not lost: it stays posted until its enable bit is set or software drops it. A fixed-priority encoder picks the lowest-index pending source and presents its vector to the CPU, together with an interrupt line that a global enable input gates.

Software reaches the block through a plain address, write-strobe and write-data bus, and reads through a combinational read-data port. Four registers sit behind it: the enable mask, a one-bit software-post enable, the vector register and the posted-event register. Reading the vector register gives the current top vector, or 00h when nothing is pending. Any write to the vector register flushes the whole pending set. A service acknowledge from the CPU retires only the top entry. The posted-event register normally drops posted bits. With the software-post enable set, it raises posted bits instead, so that software can trigger interrupts itself.

Top module: `irq_ctl`

## Requirements
- R1: Each 0-to-1 transition of a request line posts its source exactly once. A line held high posts nothing more.
- R2: The enable mask (address 0, bit i for source i, 1 = enabled, reset 00h) moves a posted bit into the pending set on the next clock edge, and the posted bit is cleared at that edge. A posted bit whose mask bit is 0 stays posted and never becomes pending.
- R3: The vector register (address 2) reads 4*(i+1), where i is the lowest-index pending source. It reads 00h when no source is pending. The `irq_vec` output always carries the same value.
- R4: Any write to address 2, whatever its data, empties the pending set, including bits being promoted at that edge. A request edge in the same cycle is still posted and becomes pending one cycle later if enabled.
- R5: A cycle with `svc_ack` high removes only the lowest-index pending bit. Other pending bits are kept.
- R6: With the software-post enable at 0, a write to address 3 clears each posted bit whose data bit is 0 and leaves posted bits whose data bit is 1. Reads of address 3 return the posted bits.
- R7: The software-post enable (address 1, bit 0, reset 0) changes address-3 writes as follows: each data bit at 1 sets its posted bit, and data bits at 0 have no effect.
- R8: `irq_out` is high exactly when `glb_en` is high and at least one source is pending.
- R9: After reset, the mask, the software-post enable, the posted bits and the pending bits are all zero. `irq_out` is low and the vector reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | N_SRC | Request lines, edge-detected |
| glb_en | input | 1 | Global interrupt enable for irq_out |
| svc_ack | input | 1 | CPU service pulse, retires the top pending source |
| bus_addr | input | 2 | Register select: 0 mask, 1 software-post enable, 2 vector, 3 posted |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| irq_out | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 8 | Vector of the top pending source, 00h if none |

## Verification
The assertions assume that reset is held low for at least one clock edge before it is released. They also assume that `svc_ack` and `bus_wr` are sampled only at rising edges, so one cycle high counts as one event. Every stimulus change is made at the falling edge, and reset is held for several cycles. The random phase picks request patterns, mask values, acknowledges and register writes freely. It can do so because no register access or input combination is illegal for this block. It also deliberately lets an acknowledge, a flush and a request edge land in the same cycle, to exercise the priority among them.

// File: rtl/irq_ctl_pkg.sv
// Package: shared register selects and vector encoding for the interrupt
// controller. Assumes at most 63 sources so every vector fits in 8 bits.
package irq_ctl_pkg;
    localparam int VEC_W = 8;

    typedef enum logic [1:0] {
        SEL_MASK = 2'd0,
        SEL_SWEN = 2'd1,
        SEL_VEC  = 2'd2,
        SEL_POST = 2'd3
    } reg_sel_e;

    // Vector code of a source: 4*(index+1), never 00h
    function automatic logic [VEC_W-1:0] vec_code(input int unsigned idx);
        return VEC_W'((idx + 1) * 4);
    endfunction
endpackage

// File: rtl/irq_edge_detect.sv
// Module: per-line rising-edge detector. Turns each 0-to-1 transition of a
// request line into a one-cycle pulse. Assumes inputs are synchronous to clk.
module irq_edge_detect #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] pulse
);
    logic [N-1:0] lvl_q;

    // Remember the previous level of every line
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl;
    end

    assign pulse = lvl & ~lvl_q;

    // R1: a line never pulses on two consecutive cycles
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ((pulse & $past(pulse)) == '0));
endmodule

// File: rtl/irq_prio_enc.sv
// Module: fixed-priority encoder. The lowest set index wins. Gives a one-hot
// selection, its vector code, and an any-set flag. Purely combinational.
module irq_prio_enc
    import irq_ctl_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     top_oh,
    output logic [VEC_W-1:0] vec,
    output logic             any
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_chain
            assign top_oh[g]  = req[g] & ~seen[g];
            assign seen[g+1]  = seen[g] | req[g];
        end
    endgenerate

    assign any = seen[N];

    // Merge the code of the single selected source
    always_comb begin
        vec = '0;
        for (int i = 0; i < N; i++)
            if (top_oh[i]) vec = vec | vec_code(i);
    end

    // R3: at most one source selected, and vector zero only when idle
    always_comb begin
        a_r3_onehot: assert ($onehot0(top_oh));
        a_r3_zero_idle: assert ((vec == '0) == (req == '0));
    end
endmodule

// File: rtl/irq_regfile.sv
// Module: software-writable control state: per-source enable mask and the
// software-post enable bit. Writes land on the clock edge of the strobe.
module irq_regfile
    import irq_ctl_pkg::*;
#(
    parameter int N      = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [N-1:0]      mask,
    output logic              swen
);
    // Update the enable mask on a write to its address
    always_ff @(posedge clk) begin
        if (!rst_n)                        mask <= '0;
        else if (wr && addr == SEL_MASK)   mask <= wdata[N-1:0];
    end

    // Update the software-post enable on a write to its address
    always_ff @(posedge clk) begin
        if (!rst_n)                        swen <= 1'b0;
        else if (wr && addr == SEL_SWEN)   swen <= wdata[0];
    end

    // R2: the mask only changes through its own register write
    a_r2_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == SEL_MASK) |=> $stable(mask));
endmodule

// File: rtl/irq_ctl.sv
// Module: prioritized interrupt controller top. Keeps posted events apart
// from pending ones. The mask gates promotion, a vector write flushes the
// pending set, and a service pulse retires the top entry. Assumes N_SRC is
// at most DATA_W and at most 63.
module irq_ctl
    import irq_ctl_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_req,
    input  logic              glb_en,
    input  logic              svc_ack,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out,
    output logic [VEC_W-1:0]  irq_vec
);
    logic [N_SRC-1:0] req_pulse, mask_q, posted_q, pending_q;
    logic [N_SRC-1:0] top_oh, promote, keep_bits, sw_set;
    logic             swen_q, any_pend, wr_vec, wr_post;

    irq_edge_detect #(.N(N_SRC)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(irq_req), .pulse(req_pulse));

    irq_regfile #(.N(N_SRC), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .mask(mask_q), .swen(swen_q));

    irq_prio_enc #(.N(N_SRC)) u_prio (
        .req(pending_q), .top_oh(top_oh), .vec(irq_vec), .any(any_pend));

    // Decode the register writes that touch event state
    always_comb begin
        wr_vec    = bus_wr && (bus_addr == SEL_VEC);
        wr_post   = bus_wr && (bus_addr == SEL_POST);
        promote   = posted_q & mask_q;
        keep_bits = (wr_post && !swen_q) ? bus_wdata[N_SRC-1:0] : '1;
        sw_set    = (wr_post &&  swen_q) ? bus_wdata[N_SRC-1:0] : '0;
    end

    // Posted events: promoted or cleared bits drop, new edges win
    always_ff @(posedge clk) begin
        if (!rst_n) posted_q <= '0;
        else        posted_q <= (posted_q & ~promote & keep_bits) | req_pulse | sw_set;
    end

    // Pending set: flush on vector write, else retire top on ack and add promotions
    always_ff @(posedge clk) begin
        if (!rst_n)      pending_q <= '0;
        else if (wr_vec) pending_q <= '0;
        else             pending_q <= (pending_q & ~(svc_ack ? top_oh : '0)) | promote;
    end

    assign irq_out = glb_en & any_pend;

    // Combinational read-back of the selected register
    always_comb begin
        unique case (bus_addr)
            SEL_MASK: bus_rdata = DATA_W'(mask_q);
            SEL_SWEN: bus_rdata = DATA_W'(swen_q);
            SEL_VEC:  bus_rdata = DATA_W'(irq_vec);
            default:  bus_rdata = DATA_W'(posted_q);
        endcase
    end

    // R4: a vector write leaves nothing pending
    a_r4_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
        wr_vec |=> (pending_q == '0));

    // R2: a bit newly pending was enabled in the previous cycle
    a_r2_gate_promote: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pending_q & ~$past(pending_q) & ~$past(mask_q)) == '0));

    // R5: the acknowledged top entry is gone unless re-promoted at once
    a_r5_ack_top: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_ack && !wr_vec) |=>
        ((pending_q & $past(top_oh) & ~$past(promote)) == '0));

    // R8: no interrupt to the CPU while globally disabled
    a_r8_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |-> !irq_out);
endmodule

// File: tb/irq_ctl_bench.sv
// Bench: directed corner cases followed by seeded random stimulus. Every
// cycle is compared against a cycle model written from the requirements.
module irq_ctl_bench;
    localparam int N = 8;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  d_req = '0;
    logic          d_gen = 1'b1, d_ack = 1'b0, d_wr = 1'b0;
    logic [1:0]    d_addr = 2'd0;
    logic [DW-1:0] d_wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq_o;
    logic [7:0]    vec_o;

    int checks = 0, fails = 0;

    // Model state
    logic [N-1:0] m_reqq = '0, m_posted = '0, m_pending = '0, m_mask = '0;
    logic         m_swen = 1'b0;

    always #5 clk = ~clk;

    irq_ctl #(.N_SRC(N), .DATA_W(DW)) u_irq_ctl (
        .clk(clk), .rst_n(rst_n), .irq_req(d_req), .glb_en(d_gen),
        .svc_ack(d_ack), .bus_addr(d_addr), .bus_wr(d_wr), .bus_wdata(d_wdata),
        .bus_rdata(rdata), .irq_out(irq_o), .irq_vec(vec_o));

    function automatic logic [N-1:0] top_of(input logic [N-1:0] p);
        for (int i = 0; i < N; i++) if (p[i]) return N'(1) << i;
        return '0;
    endfunction

    function automatic logic [7:0] vec_of(input logic [N-1:0] p);
        for (int i = 0; i < N; i++) if (p[i]) return 8'((i + 1) * 4);
        return 8'h00;
    endfunction

    function automatic logic [DW-1:0] model_read(input logic [1:0] a);
        case (a)
            2'd0:    return DW'(m_mask);
            2'd1:    return DW'(m_swen);
            2'd2:    return DW'(vec_of(m_pending));
            default: return DW'(m_posted);
        endcase
    endfunction

    task automatic expect8(input logic [7:0] got, input logic [7:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // Advance the model by one clock edge with the inputs now driven
    task automatic model_step();
        logic [N-1:0] edg, prom, keep, set, top;
        edg  = d_req & ~m_reqq;
        prom = m_posted & m_mask;
        top  = top_of(m_pending);
        keep = (d_wr && d_addr == 2'd3 && !m_swen) ? d_wdata[N-1:0] : '1;
        set  = (d_wr && d_addr == 2'd3 &&  m_swen) ? d_wdata[N-1:0] : '0;
        m_posted  = (m_posted & ~prom & keep) | edg | set;
        if (d_wr && d_addr == 2'd2) m_pending = '0;
        else m_pending = (m_pending & ~(d_ack ? top : '0)) | prom;
        if (d_wr && d_addr == 2'd0) m_mask = d_wdata[N-1:0];
        if (d_wr && d_addr == 2'd1) m_swen = d_wdata[0];
        m_reqq = d_req;
    endtask

    // Drive one cycle's inputs, check combinational outputs, take the edge
    task automatic cycle(input logic [N-1:0] rq, input logic wr, input logic [1:0] a,
                         input logic [DW-1:0] wd, input logic ack);
        string t;
        d_req = rq; d_wr = wr; d_addr = a; d_wdata = wd; d_ack = ack;
        #1;
        case (a)
            2'd0: t = "R2 mask read";
            2'd1: t = "R7 swen read";
            2'd2: t = "R3 vector read";
            default: t = "R6 posted read";
        endcase
        expect8(rdata, model_read(a), t);
        expect8(vec_o, vec_of(m_pending), "R3 irq_vec");
        expect8({7'd0, irq_o}, {7'd0, d_gen && (m_pending != '0)}, "R8 irq_out");
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a);
        d_addr = a; d_wr = 1'b0; d_ack = 1'b0;
        #1;
    endtask

    // Watchdog
    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        rd(2'd0); expect8(rdata, 8'h00, "R9 mask reset");
        rd(2'd1); expect8(rdata, 8'h00, "R9 swen reset");
        rd(2'd2); expect8(rdata, 8'h00, "R9 vector reset");
        rd(2'd3); expect8(rdata, 8'h00, "R9 posted reset");
        expect8({7'd0, irq_o}, 8'h00, "R9 irq_out reset");

        // R2: masked request stays posted, promotes once enabled
        cycle(8'h01, 0, 2'd2, 8'h00, 0);
        rd(2'd3); expect8(rdata, 8'h01, "R2 masked posted");
        rd(2'd2); expect8(rdata, 8'h00, "R2 masked not pending");
        cycle(8'h01, 0, 2'd2, 8'h00, 0);
        rd(2'd2); expect8(rdata, 8'h00, "R2 still masked");
        cycle(8'h01, 1, 2'd0, 8'h01, 0);
        cycle(8'h01, 0, 2'd2, 8'h00, 0);
        rd(2'd2); expect8(rdata, 8'h04, "R2 promoted vector");
        rd(2'd3); expect8(rdata, 8'h00, "R2 posted moved");

        // R1: held request does not post again after ack
        cycle(8'h01, 0, 2'd2, 8'h00, 0);
        cycle(8'h01, 0, 2'd2, 8'h00, 1);
        cycle(8'h01, 0, 2'd2, 8'h00, 0);
        rd(2'd2); expect8(rdata, 8'h00, "R1 held line no repost");
        cycle(8'h00, 0, 2'd2, 8'h00, 0);

        // R5: ack retires only the top entry
        cycle(8'h00, 1, 2'd0, 8'hFF, 0);
        cycle(8'h00, 1, 2'd1, 8'h01, 0);
        cycle(8'h00, 1, 2'd3, 8'h0A, 0);
        cycle(8'h00, 0, 2'd2, 8'h00, 0);
        rd(2'd2); expect8(rdata, 8'h08, "R5 top before ack");
        cycle(8'h00, 0, 2'd2, 8'h00, 1);
        rd(2'd2); expect8(rdata, 8'h10, "R5 lower kept");

        // R4: flush with a simultaneous new request edge
        cycle(8'h20, 1, 2'd2, 8'h5A, 0);
        rd(2'd2); expect8(rdata, 8'h00, "R4 flushed");
        cycle(8'h20, 0, 2'd2, 8'h00, 0);
        rd(2'd2); expect8(rdata, 8'h18, "R4 same-cycle edge kept");
        cycle(8'h20, 1, 2'd2, 8'h00, 0);
        rd(2'd2); expect8(rdata, 8'h00, "R4 flush again");

        // R6: clear register with software post disabled
        cycle(8'h20, 1, 2'd1, 8'h00, 0);
        cycle(8'h20, 1, 2'd0, 8'h00, 0);
        cycle(8'h2F, 0, 2'd3, 8'h00, 0);
        rd(2'd3); expect8(rdata, 8'h0F, "R6 posted set");
        cycle(8'h2F, 1, 2'd3, 8'hFF, 0);
        rd(2'd3); expect8(rdata, 8'h0F, "R6 ones keep");
        cycle(8'h2F, 1, 2'd3, 8'hF5, 0);
        rd(2'd3); expect8(rdata, 8'h05, "R6 zeros clear");
        cycle(8'h2F, 1, 2'd3, 8'h00, 0);
        rd(2'd3); expect8(rdata, 8'h00, "R6 all cleared");

        // R7: software posting
        cycle(8'h2F, 1, 2'd1, 8'h01, 0);
        cycle(8'h2F, 1, 2'd3, 8'h81, 0);
        rd(2'd3); expect8(rdata, 8'h81, "R7 software post");
        cycle(8'h2F, 1, 2'd3, 8'h00, 0);
        rd(2'd3); expect8(rdata, 8'h81, "R7 zeros no effect");

        // R8: global enable gating
        cycle(8'h2F, 1, 2'd0, 8'hFF, 0);
        cycle(8'h2F, 0, 2'd2, 8'h00, 0);
        d_gen = 1'b0; #1;
        expect8({7'd0, irq_o}, 8'h00, "R8 disabled");
        d_gen = 1'b1; #1;
        expect8({7'd0, irq_o}, 8'h01, "R8 enabled");

        // Seeded random phase
        void'($urandom(32'h1A2B3C4D));
        for (int k = 0; k < 3000; k++) begin
            logic [N-1:0] rq;
            logic wr;
            rq = ($urandom % 4 == 0) ? N'($urandom) : d_req;
            wr = ($urandom % 6 == 0);
            d_gen = ($urandom % 8 != 0);
            cycle(rq, wr, 2'($urandom), DW'($urandom), ($urandom % 5 == 0));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule